// File: doc/BRIEF.md
# Host-Slave Mailbox Interrupt Controller

The block joins an external host bus to an on-chip slave CPU through two mailbox channels. Each channel holds one byte travelling from host to slave (the inbound register) and one byte travelling from slave to host (the outbound register), plus a flag that marks unread inbound data. The slave CPU gets one interrupt per channel. Each interrupt is gated by an enable bit that firmware controls, and it stays asserted while the inbound byte is unread.

In the other direction, three host interrupt request latches (A, B, C) signal the host. Firmware sets a latch only by first reading it as 0 and then writing 1. It clears a latch by writing 0. The host interrupt handler releases latches as a side effect of reading an outbound register. Reading channel 0's outbound register releases B and C together, and reading channel 1's releases A. The host strobes are asynchronous to the slave clock. They pass through a two-stage synchroniser, and the block acts on their synchronised falling edge.

Top module: `hs_mailbox`

## Requirements
- R1: `slv_irq[c]` is high exactly when channel c's enable bit (control register, slave select 4, bit c) is 1 and its full flag is 1.
- R2: A host write with `host_cs_n[c]` low, `host_a0` low and a falling `host_wr_n` loads `host_din` into channel c's inbound register and sets its full flag. The same write with `host_a0` high has no effect.
- R3: A slave read of the inbound register (select 0 for channel 0, 1 for channel 1) returns the stored byte and clears that channel's full flag. If a host write to that channel takes effect on the same clock edge, the new byte is stored and the flag stays 1.
- R4: A slave write to select 2 or 3 loads the outbound register of channel 0 or 1. While `host_cs_n[c]` is low, `host_dout` shows that register when `host_a0` is 0, and shows `{7'b0, full flag}` when `host_a0` is 1. Channel 0 has priority when both selects are low.
- R5: The latch register is slave select 5, with A at bit 0, B at bit 1 and C at bit 2. A bit becomes 1 only when a slave read of select 5 returned 0 in that bit and the next slave write to select 5 carries a 1 there. A write of 1 that has no such read before it leaves the latch unchanged.
- R6: A slave write to select 5 clears every latch whose data bit is 0 on that edge. Every write to select 5 consumes all armed flags.
- R7: A host read with `host_a0` low clears latches B and C through channel 0's select and latch A through channel 1's select. A host read with `host_a0` high clears nothing.
- R8: A host-read clear lands on the third rising clock edge after `host_rd_n` falls. When it coincides with a slave write that would set the same latch, the clear wins.
- R9: While `hi_en` is low, `host_irq` is 0, the latches and armed flags are cleared, reads of select 5 return 0 and arm nothing, and writes to select 5 are ignored.
- R10: After reset, every register, full flag, enable bit, latch and armed flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low reset |
| hi_en | input | 1 | Host interface enable for the latches |
| host_cs_n | input | 2 | Active-low per-channel host chip selects |
| host_a0 | input | 1 | Host address bit: 0 selects data, 1 selects status |
| host_rd_n | input | 1 | Active-low host read strobe |
| host_wr_n | input | 1 | Active-low host write strobe |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_irq | output | 3 | Host interrupt requests A, B, C |
| slv_sel | input | 3 | Slave register select |
| slv_rd | input | 1 | Slave read strobe, one cycle |
| slv_wr | input | 1 | Slave write strobe, one cycle |
| slv_wdata | input | 8 | Slave write data |
| slv_rdata | output | 8 | Slave read data |
| slv_irq | output | 2 | Slave buffer-full interrupts |

## Verification
Two pairs of events can land on one clock edge. The first is a host read clear and a firmware set of the same latch. The second is a host write and a slave read of the same inbound register. The bench reaches each collision by dropping the host strobe and placing the slave access on the cycle just before the third rising edge. It then judges the outcome from the latch outputs and the full flags: the clear wins over the set, and the write wins over the read. A separate directed step shows that the latch still holds after two edges and is released on the third.

// File: rtl/hs_mbx_pkg.sv
`timescale 1ns/1ps
package hs_mbx_pkg;
    localparam int unsigned MBX_DW      = 8;
    localparam int unsigned MBX_NCH     = 2;
    localparam int unsigned MBX_NLATCH  = 3;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned SEL_W       = 3;

    localparam logic [SEL_W-1:0] SEL_IDR0 = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ODR0 = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
    localparam logic [SEL_W-1:0] SEL_HIRQ = 3'd5;

    localparam int unsigned LATCH_A = 0;
    localparam int unsigned LATCH_B = 1;
    localparam int unsigned LATCH_C = 2;

    typedef struct packed {
        logic [MBX_DW-1:0] idr;
        logic [MBX_DW-1:0] odr;
        logic              full;
        logic              ie;
    } chan_t;

    typedef struct packed {
        logic [MBX_NLATCH-1:0] latch;
        logic [MBX_NLATCH-1:0] armed;
    } hirq_t;

    typedef struct packed {
        logic rd_prev;
        logic wr_prev;
    } edge_t;
endpackage

// File: rtl/hs_mbx_sync.sv
`timescale 1ns/1ps
module hs_mbx_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hs_mbx_chan.sv
`timescale 1ns/1ps
module hs_mbx_chan
    import hs_mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  logic [MBX_DW-1:0] h_din,
    input  logic              s_rd_idr,
    input  logic              s_wr_odr,
    input  logic              s_wr_ie,
    input  logic              s_ie_bit,
    input  logic [MBX_DW-1:0] s_wdata,
    output chan_t             st,
    output logic              irq
);
    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (s_wr_odr) st_d.odr = s_wdata;
        if (s_wr_ie)  st_d.ie  = s_ie_bit;
        if (s_rd_idr) st_d.full = 1'b0;
        if (h_wr) begin
            st_d.idr  = h_din;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st  = st_q;
    assign irq = st_q.ie & st_q.full;
endmodule

// File: rtl/hs_mbx_hirq.sv
`timescale 1ns/1ps
module hs_mbx_hirq
    import hs_mbx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [MBX_NLATCH-1:0] wbits,
    input  logic [MBX_NLATCH-1:0] clr,
    output logic [MBX_NLATCH-1:0] latch
);
    hirq_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!en) begin
            h_d = '0;
        end else begin
            for (int i = 0; i < MBX_NLATCH; i++) begin
                if (rd && !h_q.latch[i]) h_d.armed[i] = 1'b1;
                if (wr) begin
                    if (!wbits[i])         h_d.latch[i] = 1'b0;
                    else if (h_q.armed[i]) h_d.latch[i] = 1'b1;
                    h_d.armed[i] = 1'b0;
                end
                if (clr[i]) h_d.latch[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign latch = h_q.latch;
endmodule

// File: rtl/hs_mailbox.sv
`timescale 1ns/1ps
module hs_mailbox
    import hs_mbx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hi_en,
    input  logic [MBX_NCH-1:0]    host_cs_n,
    input  logic                  host_a0,
    input  logic                  host_rd_n,
    input  logic                  host_wr_n,
    input  logic [MBX_DW-1:0]     host_din,
    output logic [MBX_DW-1:0]     host_dout,
    output logic [MBX_NLATCH-1:0] host_irq,
    input  logic [SEL_W-1:0]      slv_sel,
    input  logic                  slv_rd,
    input  logic                  slv_wr,
    input  logic [MBX_DW-1:0]     slv_wdata,
    output logic [MBX_DW-1:0]     slv_rdata,
    output logic [MBX_NCH-1:0]    slv_irq
);
    localparam int unsigned SW = MBX_NCH + 3;

    logic [SW-1:0]         strb_s;
    logic [MBX_NCH-1:0]    cs_n_s;
    logic                  a0_s, rd_s, wr_s;
    logic                  rd_fall, wr_fall;
    logic [MBX_NCH-1:0]    full_q;
    logic [MBX_NLATCH-1:0] hirq_q;
    logic [MBX_NLATCH-1:0] hclr;
    chan_t                 ch_st [MBX_NCH];
    edge_t                 e_d, e_q;

    hs_mbx_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_cs_n, host_a0, host_rd_n, host_wr_n}),
        .q     (strb_s)
    );
    assign {cs_n_s, a0_s, rd_s, wr_s} = strb_s;

    always_comb begin
        e_d.rd_prev = rd_s;
        e_d.wr_prev = wr_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '1;
        else        e_q <= e_d;
    end

    assign rd_fall = e_q.rd_prev & ~rd_s;
    assign wr_fall = e_q.wr_prev & ~wr_s;

    for (genvar c = 0; c < MBX_NCH; c++) begin : g_chan
        hs_mbx_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .h_wr     (wr_fall & ~cs_n_s[c] & ~a0_s),
            .h_din    (host_din),
            .s_rd_idr (slv_rd & (slv_sel == SEL_IDR0 + SEL_W'(c))),
            .s_wr_odr (slv_wr & (slv_sel == SEL_ODR0 + SEL_W'(c))),
            .s_wr_ie  (slv_wr & (slv_sel == SEL_CTRL)),
            .s_ie_bit (slv_wdata[c]),
            .s_wdata  (slv_wdata),
            .st       (ch_st[c]),
            .irq      (slv_irq[c])
        );
        assign full_q[c] = ch_st[c].full;
    end

    // Channel 0 outbound read releases B and C; channel 1 releases A.
    always_comb begin
        hclr          = '0;
        hclr[LATCH_B] = rd_fall & ~cs_n_s[0] & ~a0_s;
        hclr[LATCH_C] = rd_fall & ~cs_n_s[0] & ~a0_s;
        hclr[LATCH_A] = rd_fall & ~cs_n_s[1] & ~a0_s;
    end

    hs_mbx_hirq u_hirq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (hi_en),
        .rd    (slv_rd & (slv_sel == SEL_HIRQ)),
        .wr    (slv_wr & (slv_sel == SEL_HIRQ)),
        .wbits (slv_wdata[MBX_NLATCH-1:0]),
        .clr   (hclr),
        .latch (hirq_q)
    );

    assign host_irq = hirq_q & {MBX_NLATCH{hi_en}};

    always_comb begin
        slv_rdata = '0;
        for (int c = 0; c < MBX_NCH; c++) begin
            if (slv_sel == SEL_IDR0 + SEL_W'(c)) slv_rdata = ch_st[c].idr;
            if (slv_sel == SEL_ODR0 + SEL_W'(c)) slv_rdata = ch_st[c].odr;
        end
        if (slv_sel == SEL_CTRL) begin
            for (int c = 0; c < MBX_NCH; c++) begin
                slv_rdata[c]           = ch_st[c].ie;
                slv_rdata[MBX_NCH + c] = ch_st[c].full;
            end
        end
        if (slv_sel == SEL_HIRQ) slv_rdata[MBX_NLATCH-1:0] = hirq_q;
    end

    always_comb begin
        host_dout = '0;
        for (int c = MBX_NCH - 1; c >= 0; c--) begin
            if (!host_cs_n[c]) begin
                if (host_a0) host_dout = MBX_DW'(ch_st[c].full);
                else         host_dout = ch_st[c].odr;
            end
        end
    end
endmodule

// File: rtl/hs_mailbox_chk.sv
`timescale 1ns/1ps
module hs_mailbox_chk
    import hs_mbx_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  hi_en,
    input logic [SEL_W-1:0]      slv_sel,
    input logic                  slv_rd,
    input logic                  slv_wr,
    input logic [MBX_DW-1:0]     slv_wdata,
    input logic [MBX_NCH-1:0]    slv_irq,
    input logic [MBX_NLATCH-1:0] host_irq,
    input logic                  rd_fall,
    input logic                  wr_fall,
    input logic [MBX_NCH-1:0]    cs_n_s,
    input logic                  a0_s,
    input logic [MBX_NCH-1:0]    full_q,
    input logic [MBX_NLATCH-1:0] hirq_q
);
    logic hw0, hr0, hr1;
    assign hw0 = wr_fall & ~cs_n_s[0] & ~a0_s;
    assign hr0 = rd_fall & ~cs_n_s[0] & ~a0_s;
    assign hr1 = rd_fall & ~cs_n_s[1] & ~a0_s;

    assert_irq_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slv_irq[0]) |-> $past(hw0 || (slv_wr && slv_sel == SEL_CTRL)));

    assert_hwrite_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hw0 |=> full_q[0]);

    assert_sread_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_rd && slv_sel == SEL_IDR0 && !hw0) |=> !full_q[0]);

    assert_no_unarmed_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq[LATCH_B]) |-> $past(slv_wr && slv_sel == SEL_HIRQ && slv_wdata[LATCH_B]));

    assert_wr0_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_wr && slv_sel == SEL_HIRQ && !slv_wdata[LATCH_A]) |=> !hirq_q[LATCH_A]);

    assert_odr0_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hr0 |=> (!hirq_q[LATCH_B] && !hirq_q[LATCH_C]));

    assert_odr1_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hr1 |=> !hirq_q[LATCH_A]);

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hr0 && slv_wr && slv_sel == SEL_HIRQ) |=> !host_irq[LATCH_C]);

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_en |=> hirq_q == '0);
endmodule

bind hs_mailbox hs_mailbox_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_en     (hi_en),
    .slv_sel   (slv_sel),
    .slv_rd    (slv_rd),
    .slv_wr    (slv_wr),
    .slv_wdata (slv_wdata),
    .slv_irq   (slv_irq),
    .host_irq  (host_irq),
    .rd_fall   (rd_fall),
    .wr_fall   (wr_fall),
    .cs_n_s    (cs_n_s),
    .a0_s      (a0_s),
    .full_q    (full_q),
    .hirq_q    (hirq_q)
);

// File: tb/tb_hs_mailbox.sv
`timescale 1ns/1ps
module tb_hs_mailbox;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_en = 1'b1;
    logic [1:0] host_cs_n = 2'b11;
    logic       host_a0 = 1'b1;
    logic       host_rd_n = 1'b1;
    logic       host_wr_n = 1'b1;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic [2:0] host_irq;
    logic [2:0] slv_sel = '0;
    logic       slv_rd = 1'b0;
    logic       slv_wr = 1'b0;
    logic [7:0] slv_wdata = '0;
    logic [7:0] slv_rdata;
    logic [1:0] slv_irq;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    logic [7:0] m_idr [2];
    logic [7:0] m_odr [2];
    logic [1:0] m_full, m_ie;
    logic [2:0] m_latch, m_armed;
    logic       m_en;

    always #4 clk = ~clk;

    hs_mailbox dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_slv_rdata(input logic [2:0] sel);
        case (sel)
            3'd0, 3'd1: return m_idr[sel[0]];
            3'd2, 3'd3: return m_odr[sel[0]];
            3'd4:       return {4'b0, m_full, m_ie};
            3'd5:       return {5'b0, m_en ? m_latch : 3'b000};
            default:    return 8'h00;
        endcase
    endfunction

    function automatic void mdl_slave(input logic rd, input logic wr, input logic [2:0] sel,
                                      input logic [7:0] wd);
        if (wr) begin
            if (sel == 3'd2 || sel == 3'd3) m_odr[sel[0]] = wd;
            if (sel == 3'd4) m_ie = wd[1:0];
            if (sel == 3'd5 && m_en) begin
                for (int i = 0; i < 3; i++) begin
                    if (!wd[i]) m_latch[i] = 1'b0;
                    else if (m_armed[i]) m_latch[i] = 1'b1;
                end
                m_armed = 3'b000;
            end
        end
        if (rd) begin
            if (sel == 3'd0 || sel == 3'd1) m_full[sel[0]] = 1'b0;
            if (sel == 3'd5 && m_en) m_armed = m_armed | ~m_latch;
        end
    endfunction

    function automatic logic [7:0] exp_host_dout(input int ch, input logic a0);
        return a0 ? {7'b0, m_full[ch]} : m_odr[ch];
    endfunction

    function automatic void mdl_host(input int ch, input logic is_rd, input logic a0,
                                     input logic [7:0] din);
        if (a0) return;
        if (is_rd) begin
            if (ch == 0) m_latch[2:1] = 2'b00;
            else         m_latch[0]   = 1'b0;
        end else begin
            m_idr[ch]  = din;
            m_full[ch] = 1'b1;
        end
    endfunction

    task automatic check_irqs(input string req);
        check({req, " host_irq"}, 32'(host_irq), 32'(m_latch & {3{m_en}}));
        check({req, " slv_irq"}, 32'(slv_irq), 32'(m_ie & m_full));
    endtask

    // Called at a negedge; returns at a negedge.
    task automatic slv_op(input logic rd, input logic wr, input logic [2:0] sel,
                          input logic [7:0] wd, input string req);
        slv_rd = rd; slv_wr = wr; slv_sel = sel; slv_wdata = wd;
        #1;
        if (rd) check({req, " slv_rdata"}, 32'(slv_rdata), 32'(exp_slv_rdata(sel)));
        @(posedge clk); @(negedge clk);
        slv_rd = 1'b0; slv_wr = 1'b0;
        mdl_slave(rd, wr, sel, wd);
    endtask

    task automatic host_op(input int ch, input logic is_rd, input logic a0,
                           input logic [7:0] din, input string req);
        host_cs_n = ~(2'b01 << ch); host_a0 = a0; host_din = din;
        if (is_rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (is_rd) check({req, " host_dout"}, 32'(host_dout), 32'(exp_host_dout(ch, a0)));
        mdl_host(ch, is_rd, a0, din);
        host_rd_n = 1'b1; host_wr_n = 1'b1; host_cs_n = 2'b11; host_a0 = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_all_latches();
        slv_op(1'b0, 1'b1, 3'd5, 8'h00, "R6");
        slv_op(1'b1, 1'b0, 3'd5, 8'h00, "R5");
        slv_op(1'b0, 1'b1, 3'd5, 8'h07, "R5");
    endtask

    initial begin
        #(8ns * 150000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c3a_5e07));
        m_idr[0] = '0; m_idr[1] = '0; m_odr[0] = '0; m_odr[1] = '0;
        m_full = '0; m_ie = '0; m_latch = '0; m_armed = '0; m_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check_irqs("R10");
        slv_op(1'b1, 1'b0, 3'd4, 8'h00, "R10");
        slv_op(1'b1, 1'b0, 3'd5, 8'h00, "R10");
        check("R10 host_dout", 32'(host_dout), 32'h0);

        // R5: write 1 with no preceding read of 0 must not set
        slv_op(1'b0, 1'b1, 3'd5, 8'h00, "R6");
        slv_op(1'b0, 1'b1, 3'd5, 8'h07, "R5");
        check_irqs("R5 unarmed");
        set_all_latches();
        check("R5 set", 32'(host_irq), 32'h7);

        // R6: write 0 clears B only; A write 1 unarmed keeps A
        slv_op(1'b0, 1'b1, 3'd5, 8'h05, "R6");
        check("R6 clear", 32'(host_irq), 32'h5);

        // R7: host read a0=1 clears nothing; ODR0 read clears B,C; ODR1 clears A
        slv_op(1'b0, 1'b1, 3'd2, 8'hA5, "R4");
        slv_op(1'b0, 1'b1, 3'd3, 8'h3C, "R4");
        set_all_latches();
        host_op(0, 1'b1, 1'b1, 8'h00, "R7");
        check("R7 status read", 32'(host_irq), 32'h7);
        host_op(0, 1'b1, 1'b0, 8'h00, "R7");
        check("R7 odr0", 32'(host_irq), 32'h1);
        host_op(1, 1'b1, 1'b0, 8'h00, "R7");
        check("R7 odr1", 32'(host_irq), 32'h0);

        // R8: clear lands on third edge
        set_all_latches();
        host_cs_n = 2'b10; host_a0 = 1'b0; host_rd_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8 before 3rd edge", 32'(host_irq), 32'h7);
        @(posedge clk); @(negedge clk);
        check("R8 after 3rd edge", 32'(host_irq), 32'h1);
        mdl_host(0, 1'b1, 1'b0, 8'h00);
        host_rd_n = 1'b1; host_cs_n = 2'b11; host_a0 = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);

        // R8: clear beats a slave set on the same edge
        slv_op(1'b0, 1'b1, 3'd5, 8'h00, "R6");
        slv_op(1'b1, 1'b0, 3'd5, 8'h00, "R5");
        host_cs_n = 2'b10; host_a0 = 1'b0; host_rd_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        slv_wr = 1'b1; slv_sel = 3'd5; slv_wdata = 8'h07;
        @(posedge clk); @(negedge clk);
        slv_wr = 1'b0;
        mdl_slave(1'b0, 1'b1, 3'd5, 8'h07);
        mdl_host(0, 1'b1, 1'b0, 8'h00);
        check("R8 collision", 32'(host_irq), 32'h1);
        host_rd_n = 1'b1; host_cs_n = 2'b11; host_a0 = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);

        // R2 / R1: host write loads, a0=1 write ignored
        slv_op(1'b0, 1'b1, 3'd4, 8'h03, "R1");
        host_op(0, 1'b0, 1'b0, 8'h5A, "R2");
        check_irqs("R1");
        host_op(1, 1'b0, 1'b1, 8'hEE, "R2");
        check("R2 a0 ignored", 32'(slv_irq), 32'h1);
        slv_op(1'b1, 1'b0, 3'd1, 8'h00, "R2");
        slv_op(1'b1, 1'b0, 3'd0, 8'h00, "R3");
        check("R3 full cleared", 32'(slv_irq), 32'h0);

        // R3: host write and slave read on same edge, write wins
        host_cs_n = 2'b10; host_a0 = 1'b0; host_din = 8'hC3; host_wr_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        slv_rd = 1'b1; slv_sel = 3'd0;
        #1 check("R3 old data", 32'(slv_rdata), 32'(m_idr[0]));
        @(posedge clk); @(negedge clk);
        slv_rd = 1'b0;
        mdl_slave(1'b1, 1'b0, 3'd0, 8'h00);
        mdl_host(0, 1'b0, 1'b0, 8'hC3);
        check("R3 write wins", 32'(slv_irq), 32'h1);
        host_wr_n = 1'b1; host_cs_n = 2'b11; host_a0 = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        slv_op(1'b1, 1'b0, 3'd0, 8'h00, "R3");

        // R9: interface disabled
        set_all_latches();
        hi_en = 1'b0;
        #1 check("R9 masked", 32'(host_irq), 32'h0);
        @(posedge clk); @(negedge clk);
        m_en = 1'b0; m_latch = '0; m_armed = '0;
        slv_op(1'b1, 1'b0, 3'd5, 8'h00, "R9");
        slv_op(1'b0, 1'b1, 3'd5, 8'h07, "R9");
        hi_en = 1'b1; m_en = 1'b1;
        @(negedge clk);
        check("R9 nothing set", 32'(host_irq), 32'h0);
        slv_op(1'b0, 1'b1, 3'd5, 8'h07, "R9");
        check("R9 no arm while off", 32'(host_irq), 32'h0);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            int ch;
            op = $urandom_range(0, 8);
            ch = $urandom_range(0, 1);
            case (op)
                0: host_op(ch, 1'b0, ($urandom_range(0, 3) == 0), 8'($urandom), "R2");
                1: host_op(ch, 1'b1, ($urandom_range(0, 3) == 0), 8'h00, "R4");
                2: slv_op(1'b1, 1'b0, 3'(ch), 8'h00, "R3");
                3: slv_op(1'b0, 1'b1, 3'(2 + ch), 8'($urandom), "R4");
                4: slv_op(1'b0, 1'b1, 3'd4, 8'($urandom), "R1");
                5: slv_op(1'b1, 1'b0, 3'd5, 8'h00, "R5");
                6: slv_op(1'b0, 1'b1, 3'd5, 8'($urandom), "R6");
                7: slv_op(1'b1, 1'b0, 3'd4, 8'h00, "R1");
                default: begin
                    if ($urandom_range(0, 3) == 0) begin
                        hi_en = ~hi_en;
                        @(posedge clk); @(negedge clk);
                        m_en = hi_en;
                        if (!m_en) begin m_latch = '0; m_armed = '0; end
                    end
                end
            endcase
            check_irqs("R7");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule